// File: doc/BRIEF.md
# DS0 Fixed Pattern Sequencer

This block produces the fixed, byte-aligned stress patterns used to exercise a 64 kbit/s DS0 channel. The patterns are: alternating bursts of all-ones and all-zero bytes, bursts of a flag-like byte against zeros, a steady average-traffic byte, a steady low-density byte, and a long composite run that chains the first four together. It also produces the idle-transition pattern, which is seven near-full bytes followed by one full byte. The pattern code can be changed during a run; the change takes effect at the next byte.

Each pulse on the byte-rate enable emits one byte. That byte appears one cycle later on a parallel port with a valid strobe. The same byte is also shifted out serially over the next eight clocks, first wire bit first. A start pulse restarts the selected pattern from its first byte.

Each pattern is described as a list of segments. A segment is a byte value and a repeat count. A segment index and a repeat counter walk the list and wrap when they reach its end.

Top module: `ds0_fixed_pattern_gen`

## Requirements
- R1: After reset `byte_valid` and `bit_valid` are low, and the sequence stands at the first byte of pattern code 0.
- R2: Every cycle with `byte_en` high is followed by exactly one cycle with `byte_valid` high, carrying the byte. Without `byte_en`, `byte_valid` stays low. `byte_out[7]` is the first bit on the wire and `byte_out[0]` the last.
- R3: Code 0 emits 100 bytes of 0xFF, then 100 bytes of 0x00, and repeats.
- R4: Code 1 emits 100 bytes of 0x7E (wire 01111110), then 100 bytes of 0x00, and repeats.
- R5: Code 2 emits 0x4C (wire 01001100) on every byte. This is hex 32 sent LSB first.
- R6: Code 3 emits 0x02 (wire 00000010) on every byte. This is hex 40 sent LSB first.
- R7: Code 4 emits a 2000-byte composite run and then wraps. The run is four pairs of (100 × 0xFF, 100 × 0x00), then four pairs of (100 × 0x7E, 100 × 0x00), then 200 × 0x4C, then 200 × 0x02.
- R8: Code 5 emits seven bytes of 0xFE (wire 11111110, hex 7F sent LSB first), then one 0xFF, with a period of 8 bytes.
- R9: Codes 6 and 7 emit 0x00 on every byte.
- R10: A `start` pulse makes the next emitted byte the first byte of the selected pattern. This holds whether or not `byte_en` is high in the same cycle. A `start` without `byte_en` emits nothing.
- R11: A change of `pat_sel` is acted on only at a `byte_en`. If the code then differs from the code of the previous byte, the new pattern begins at its first byte. A code that changes and changes back between two enables does not disturb the position.
- R12: After each `byte_en`, `bit_valid` is high for the next 8 cycles. During those cycles `bit_out` carries `byte_out[7]` down to `byte_out[0]`, one bit per cycle. A new `byte_en` reloads the shifter, so enables must be at least 8 cycles apart for complete serial bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart the selected pattern at its first byte |
| pat_sel | input | 3 | Pattern code 0..7 |
| byte_en | input | 1 | Byte-rate enable; emits one byte |
| byte_out | output | 8 | Emitted byte, bit 7 first on the wire |
| byte_valid | output | 1 | High one cycle after each `byte_en` |
| bit_out | output | 1 | Serial wire bit |
| bit_valid | output | 1 | Serial bit qualifier |

## Verification
The bench crosses the 100-byte and 200-byte segment boundaries of each burst pattern, and it wraps the full 2000-byte composite run. A repeat counter that is off by one would move every boundary and break those counts. A composite schedule with a wrong or misordered entry would emit the wrong value in a segment, and wrong wrap logic would not return to the first ones burst. The bench pulses `start` both alone and together with `byte_en`. A design that ignores the start pulse, or that handles only one of the two forms, keeps emitting from the middle of a burst. The bench also toggles `pat_sel` away and back between enables, and it sends back-to-back enables. A design that acts on `pat_sel` between enables would lose its place, and a bit-order or latency slip would put the serial stream out of step with the parallel byte.

// File: rtl/ds0_pat_pkg.sv
package ds0_pat_pkg;

  typedef enum logic [2:0] {
    PAT_BURST  = 3'd0,
    PAT_FLAG   = 3'd1,
    PAT_AVG    = 3'd2,
    PAT_LOW    = 3'd3,
    PAT_MIX    = 3'd4,
    PAT_XITION = 3'd5,
    PAT_RSV6   = 3'd6,
    PAT_RSV7   = 3'd7
  } pat_e;

  localparam logic [7:0] WIRE_ONES = 8'hFF;
  localparam logic [7:0] WIRE_ZERO = 8'h00;

  // Hex symbols go to the wire LSB first; the wire byte holds its first bit in bit 7.
  function automatic logic [7:0] hex_to_wire(input logic [7:0] h);
    logic [7:0] w;
    for (int k = 0; k < 8; k++) w[7-k] = h[k];
    return w;
  endfunction

endpackage

// File: rtl/ds0_seg_rom.sv
module ds0_seg_rom
  import ds0_pat_pkg::*;
#(
  parameter int SHORT_RUN = 100,
  parameter int LONG_RUN  = 200,
  parameter int XN_RUN    = 7,
  parameter int MIX_PAIRS = 4,
  parameter int SEG_W     = 5,
  parameter int CNT_W     = 8
) (
  input  pat_e             pat,
  input  logic [SEG_W-1:0] seg,
  output logic [7:0]       value,
  output logic [CNT_W-1:0] run_len,
  output logic             last_seg
);

  localparam int MIX_HALF = 2 * MIX_PAIRS;
  localparam logic [7:0] WIRE_FLAG = 8'h7E;

  int seg_i;
  assign seg_i = int'(seg);

  always_comb begin
    value    = WIRE_ZERO;
    run_len  = CNT_W'(1);
    last_seg = 1'b1;
    case (pat)
      PAT_BURST: begin
        value    = seg[0] ? WIRE_ZERO : WIRE_ONES;
        run_len  = CNT_W'(SHORT_RUN);
        last_seg = seg[0];
      end
      PAT_FLAG: begin
        value    = seg[0] ? WIRE_ZERO : WIRE_FLAG;
        run_len  = CNT_W'(SHORT_RUN);
        last_seg = seg[0];
      end
      PAT_AVG: begin
        value    = hex_to_wire(8'h32);
        run_len  = CNT_W'(LONG_RUN);
        last_seg = 1'b1;
      end
      PAT_LOW: begin
        value    = hex_to_wire(8'h40);
        run_len  = CNT_W'(LONG_RUN);
        last_seg = 1'b1;
      end
      PAT_MIX: begin
        if (seg_i < MIX_HALF) begin
          value   = seg[0] ? WIRE_ZERO : WIRE_ONES;
          run_len = CNT_W'(SHORT_RUN);
        end else if (seg_i < 2 * MIX_HALF) begin
          value   = seg[0] ? WIRE_ZERO : WIRE_FLAG;
          run_len = CNT_W'(SHORT_RUN);
        end else if (seg_i == 2 * MIX_HALF) begin
          value   = hex_to_wire(8'h32);
          run_len = CNT_W'(LONG_RUN);
        end else begin
          value   = hex_to_wire(8'h40);
          run_len = CNT_W'(LONG_RUN);
        end
        last_seg = (seg_i >= 2 * MIX_HALF + 1);
      end
      PAT_XITION: begin
        value    = seg[0] ? WIRE_ONES : hex_to_wire(8'h7F);
        run_len  = seg[0] ? CNT_W'(1) : CNT_W'(XN_RUN);
        last_seg = seg[0];
      end
      default: begin
        value    = WIRE_ZERO;
        run_len  = CNT_W'(1);
        last_seg = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ds0_seq_ctrl.sv
module ds0_seq_ctrl
  import ds0_pat_pkg::*;
#(
  parameter int SEG_W = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             byte_en,
  input  pat_e             pat_sel,
  input  logic [CNT_W-1:0] run_len,
  input  logic             last_seg,
  output logic [SEG_W-1:0] q_seg
);

  pat_e             cur_pat;
  logic [SEG_W-1:0] seg_r;
  logic [CNT_W-1:0] rep_r;
  logic             restart;
  logic [CNT_W-1:0] eff_rep;
  logic             seg_end;

  always_comb begin
    restart = start || (pat_sel != cur_pat);
    q_seg   = restart ? '0 : seg_r;
    eff_rep = restart ? '0 : rep_r;
    seg_end = (eff_rep == run_len - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pat <= PAT_BURST;
      seg_r   <= '0;
      rep_r   <= '0;
    end else if (byte_en) begin
      cur_pat <= pat_sel;
      if (seg_end) begin
        rep_r <= '0;
        seg_r <= last_seg ? '0 : q_seg + SEG_W'(1);
      end else begin
        rep_r <= eff_rep + CNT_W'(1);
        seg_r <= q_seg;
      end
    end else if (start) begin
      cur_pat <= pat_sel;
      seg_r   <= '0;
      rep_r   <= '0;
    end
  end

endmodule

// File: rtl/ds0_byte_serializer.sv
module ds0_byte_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         ser_bit,
  output logic         ser_valid
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= din;
      cnt <= CW'(W);
    end else if (cnt != '0) begin
      sh  <= {sh[W-2:0], 1'b0};
      cnt <= cnt - CW'(1);
    end
  end

  assign ser_bit   = sh[W-1];
  assign ser_valid = (cnt != '0);

endmodule

// File: rtl/ds0_fixed_pattern_gen.sv
module ds0_fixed_pattern_gen
  import ds0_pat_pkg::*;
#(
  parameter int SHORT_RUN = 100,
  parameter int LONG_RUN  = 200,
  parameter int XN_RUN    = 7,
  parameter int MIX_PAIRS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] pat_sel,
  input  logic       byte_en,
  output logic [7:0] byte_out,
  output logic       byte_valid,
  output logic       bit_out,
  output logic       bit_valid
);

  localparam int MAX_RUN = (SHORT_RUN > LONG_RUN) ?
                           ((SHORT_RUN > XN_RUN) ? SHORT_RUN : XN_RUN) :
                           ((LONG_RUN > XN_RUN) ? LONG_RUN : XN_RUN);
  localparam int CNT_W   = $clog2(MAX_RUN + 1);
  localparam int SEG_W   = $clog2(4 * MIX_PAIRS + 2);

  pat_e             sel_e;
  logic [SEG_W-1:0] q_seg;
  logic [7:0]       rom_value;
  logic [CNT_W-1:0] rom_run;
  logic             rom_last;

  assign sel_e = pat_e'(pat_sel);

  ds0_seq_ctrl #(.SEG_W(SEG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .byte_en  (byte_en),
    .pat_sel  (sel_e),
    .run_len  (rom_run),
    .last_seg (rom_last),
    .q_seg    (q_seg)
  );

  ds0_seg_rom #(
    .SHORT_RUN (SHORT_RUN),
    .LONG_RUN  (LONG_RUN),
    .XN_RUN    (XN_RUN),
    .MIX_PAIRS (MIX_PAIRS),
    .SEG_W     (SEG_W),
    .CNT_W     (CNT_W)
  ) u_rom (
    .pat      (sel_e),
    .seg      (q_seg),
    .value    (rom_value),
    .run_len  (rom_run),
    .last_seg (rom_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out   <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= byte_en;
      if (byte_en) byte_out <= rom_value;
    end
  end

  ds0_byte_serializer #(.W(8)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .load      (byte_en),
    .din       (rom_value),
    .ser_bit   (bit_out),
    .ser_valid (bit_valid)
  );

endmodule

// File: rtl/ds0_pat_checker.sv
module ds0_pat_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] pat_sel,
  input logic       byte_en,
  input logic [7:0] byte_out,
  input logic       byte_valid,
  input logic       bit_out,
  input logic       bit_valid
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!byte_valid && !bit_valid));

  assert_valid_follows_en_R2: assert property (@(posedge clk) disable iff (rst)
    byte_en |=> byte_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !byte_en |=> !byte_valid);

  assert_avg_byte_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && $past(pat_sel) == 3'd2) |-> byte_out == 8'h4C);

  assert_low_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && $past(pat_sel) == 3'd3) |-> byte_out == 8'h02);

  assert_xition_values_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && $past(pat_sel) == 3'd5) |-> (byte_out == 8'hFE || byte_out == 8'hFF));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && $past(pat_sel) >= 3'd6) |-> byte_out == 8'h00);

  assert_serial_head_R12: assert property (@(posedge clk) disable iff (rst)
    byte_en |=> (bit_valid && bit_out == byte_out[7]));

endmodule

bind ds0_fixed_pattern_gen ds0_pat_checker i_ds0_pat_checker (
  .clk        (clk),
  .rst        (rst),
  .pat_sel    (pat_sel),
  .byte_en    (byte_en),
  .byte_out   (byte_out),
  .byte_valid (byte_valid),
  .bit_out    (bit_out),
  .bit_valid  (bit_valid)
);

// File: tb/test_ds0_fixed_pattern_gen.sv
module test_ds0_fixed_pattern_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] pat_sel = 3'd0;
  logic       byte_en = 1'b0;
  logic [7:0] byte_out;
  logic       byte_valid;
  logic       bit_out;
  logic       bit_valid;

  ds0_fixed_pattern_gen i_ds0_fixed_pattern_gen (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pat_sel    (pat_sel),
    .byte_en    (byte_en),
    .byte_out   (byte_out),
    .byte_valid (byte_valid),
    .bit_out    (bit_out),
    .bit_valid  (bit_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int ref_pat = 0;
  int ref_idx = 0;
  bit exp_bv = 1'b0;
  logic [7:0] exp_byte = 8'h00;
  bit exp_bits[$];

  function automatic int period_of(input int p);
    case (p)
      0, 1, 2, 3: return 200;
      4:          return 2000;
      5:          return 8;
      default:    return 1;
    endcase
  endfunction

  function automatic logic [7:0] pat_byte(input int p, input int i);
    case (p)
      0: return (i < 100) ? 8'hFF : 8'h00;
      1: return (i < 100) ? 8'h7E : 8'h00;
      2: return 8'h4C;
      3: return 8'h02;
      4: begin
        if (i < 800)       return ((i / 100) % 2 == 1) ? 8'h00 : 8'hFF;
        else if (i < 1600) return ((i / 100) % 2 == 1) ? 8'h00 : 8'h7E;
        else if (i < 1800) return 8'h4C;
        else               return 8'h02;
      end
      5: return (i < 7) ? 8'hFE : 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic cycle(input bit s, input logic [2:0] sel, input bit en, input string tag);
    start   = s;
    pat_sel = sel;
    byte_en = en;
    if (en) begin
      if (s || int'(sel) != ref_pat) ref_idx = 0;
      ref_pat  = int'(sel);
      exp_byte = pat_byte(ref_pat, ref_idx);
      ref_idx  = (ref_idx + 1) % period_of(ref_pat);
      exp_bv   = 1'b1;
      exp_bits.delete();
      for (int k = 7; k >= 0; k--) exp_bits.push_back(exp_byte[k]);
    end else begin
      exp_bv = 1'b0;
      if (s) begin
        ref_idx = 0;
        ref_pat = int'(sel);
      end
      if (exp_bits.size() > 0) void'(exp_bits.pop_front());
    end
    @(negedge clk);
    check(exp_bv ? tag : "R2", "byte_valid", int'(byte_valid), int'(exp_bv));
    if (exp_bv) check(tag, "byte_out", int'(byte_out), int'(exp_byte));
    check("R12", "bit_valid", int'(bit_valid), (exp_bits.size() > 0) ? 1 : 0);
    if (exp_bits.size() > 0) check("R12", "bit_out", int'(bit_out), int'(exp_bits[0]));
  endtask

  task automatic send(input logic [2:0] sel, input int n, input int gap, input string tag);
    for (int j = 0; j < n; j++) begin
      cycle(1'b0, sel, 1'b1, tag);
      for (int g = 1; g < gap; g++) cycle(1'b0, sel, 1'b0, tag);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "byte_valid after reset", int'(byte_valid), 0);
    check("R1", "bit_valid after reset", int'(bit_valid), 0);
    cycle(1'b0, 3'd0, 1'b0, "R1");
    cycle(1'b0, 3'd0, 1'b0, "R1");
    // R1: first byte after reset is the head of code 0
    send(3'd0, 1, 8, "R1");
    // R3: burst pattern across both 100-byte boundaries and the wrap
    send(3'd0, 209, 8, "R3");
    // R4: flag pattern (switch restarts at its head)
    send(3'd1, 205, 8, "R4");
    // R5, R6: steady bytes
    send(3'd2, 210, 8, "R5");
    send(3'd3, 210, 8, "R6");
    // R7: composite run through its wrap
    send(3'd4, 2010, 8, "R7");
    // R8: transition pattern
    send(3'd5, 20, 8, "R8");
    // R9: reserved codes
    send(3'd6, 5, 8, "R9");
    send(3'd7, 5, 8, "R9");
    // R10: start pulse alone, then start together with an enable
    send(3'd0, 50, 8, "R10");
    cycle(1'b1, 3'd0, 1'b0, "R10");
    send(3'd0, 120, 8, "R10");
    send(3'd0, 30, 8, "R10");
    cycle(1'b1, 3'd0, 1'b1, "R10");
    for (int g = 1; g < 8; g++) cycle(1'b0, 3'd0, 1'b0, "R10");
    send(3'd0, 110, 8, "R10");
    // R11: select toggled away and back between enables keeps the position
    send(3'd0, 30, 8, "R11");
    cycle(1'b0, 3'd1, 1'b0, "R11");
    cycle(1'b0, 3'd5, 1'b0, "R11");
    cycle(1'b0, 3'd0, 1'b0, "R11");
    send(3'd0, 80, 8, "R11");
    cycle(1'b0, 3'd5, 1'b0, "R11");
    send(3'd5, 10, 8, "R11");
    // R2: back-to-back enables
    send(3'd4, 20, 1, "R2");
    for (int g = 0; g < 10; g++) cycle(1'b0, 3'd4, 1'b0, "R12");
    finish_run();
  end

endmodule